// File: doc/BRIEF.md
# Serial Command Periphery Controller

This block is the control state machine at the edge of a pixel array. It takes a 14-bit command word from one serial pin, decodes it and runs the operation that the word names. The operations are a column readout, a per-pixel configuration load, a write to a global configuration register and a reset of the array. It drives per-column readout and load strobes to the column ends. It enables exactly one of two array clocks, the counting clock or the readout clock, or neither. It also passes the shutter, analog power-off and test-pulse pins through to the array.

A readout or configuration command selects a group of columns. The group is one, two or four adjacent columns from a start column, or every column. The block asks for the readout clock and waits until that clock is enabled. It then holds the selected strobes for a fixed number of cycles. A global write takes its 14-bit payload from the next serial word. A configuration load over the whole array marks the array as configured, and test pulses reach the array only while that mark is set.

Top module: `cmd_periph_ctrl`

## Requirements
- R1: Bits are shifted in MSB first, one bit per clock while `cmd_sen` is high. A word is taken when its 14th bit arrives. If `cmd_sen` goes low, a partly shifted word is discarded and the next bit starts a new word.
- R2: Command layout: bits 13:11 are the opcode, bits 10:9 the group size and bits 8:0 the start column or register address. Opcode 001 is readout, 010 is pixel configuration, 011 is global write and 100 is array reset. Any other opcode is ignored and has no effect at the ports.
- R3: Group size 00 selects 1 column, 01 selects 2, 10 selects 4 and 11 selects all columns. The group starts at the start column. Columns above NCOL-1 are dropped from the group.
- R4: A readout raises `col_read` on exactly the selected columns for RO_CYCLES consecutive cycles. `col_load` stays zero during a readout.
- R5: A pixel configuration command raises `col_load` on exactly the selected columns for CFG_CYCLES consecutive cycles. `col_read` stays zero during the load.
- R6: A global write uses the next 14-bit word as its payload. It produces one single-cycle `gcfg_we` pulse, with `gcfg_addr` set to bits 8:0 of the command and `gcfg_data` set to the payload.
- R7: Array reset produces one single-cycle `arr_rst` pulse and clears `cfg_done`.
- R8: `cfg_done` is set when a pixel configuration of all columns completes. A load of a partial group does not set it.
- R9: Readout or configuration commands that arrive while an operation is under way are ignored.
- R10: The readout clock is enabled while a readout or configuration is pending or running. The counting clock is enabled while the block is idle and the shutter is open. Otherwise neither clock is enabled. The two enables are never high together, and a switch from one to the other passes through at least one cycle with both low.
- R11: Column strobes are high only while the readout clock is enabled.
- R12: `shutter_out` and `pwroff_out` follow their pins one cycle later. `tpulse_out` follows `tpulse_pin` one cycle later, but only while `cfg_done` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_sen | input | 1 | Serial shift enable / word framing |
| cmd_sdi | input | 1 | Serial command data, MSB first |
| shutter_pin | input | 1 | External shutter request |
| pwroff_pin | input | 1 | External analog power-off request |
| tpulse_pin | input | 1 | External test-pulse request |
| col_read | output | NCOL | Per-column readout strobes |
| col_load | output | NCOL | Per-column configuration load strobes |
| gcfg_we | output | 1 | Global register write pulse |
| gcfg_addr | output | 9 | Global register address |
| gcfg_data | output | 14 | Global register payload |
| arr_rst | output | 1 | Array reset pulse |
| cfg_done | output | 1 | Array fully configured |
| acq_clk_en | output | 1 | Counting clock enable to the array |
| ro_clk_en | output | 1 | Readout clock enable to the array |
| shutter_out | output | 1 | Registered shutter to the array |
| pwroff_out | output | 1 | Registered analog power-off |
| tpulse_out | output | 1 | Gated, registered test pulse |

## Verification
The assertions assume that the external pins are synchronous to `clk` and are held low while reset is asserted. They also assume that `cmd_sen` frames whole words, so that no word arrives in the middle of another word. The bench changes every input on the falling edge and keeps all pins low through reset. It sends each command as one unbroken 14-cycle burst, except in the abort test, which lowers `cmd_sen` on purpose. Back-to-back words are sent only to check that commands arriving during an operation are dropped.

// File: rtl/cmd_periph_pkg.sv
package cmd_periph_pkg;
  localparam int CMD_W = 14;
  localparam int OP_W  = 3;
  localparam int SZ_W  = 2;
  localparam int ARG_W = CMD_W - OP_W - SZ_W;

  localparam logic [OP_W-1:0] OP_READ = 3'd1;
  localparam logic [OP_W-1:0] OP_PCFG = 3'd2;
  localparam logic [OP_W-1:0] OP_GWR  = 3'd3;
  localparam logic [OP_W-1:0] OP_ARST = 3'd4;

  localparam logic [SZ_W-1:0] SZ_ALL  = 2'b11;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [SZ_W-1:0]  sz;
    logic [ARG_W-1:0] arg;
  } cmd_t;

  typedef enum logic [1:0] {S_IDLE, S_WDATA, S_CLKW, S_RUN} seq_e;
endpackage

// File: rtl/cmd_shift_rx.sv
module cmd_shift_rx
  import cmd_periph_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sen,
  input  logic             sdi,
  output logic             word_vld,
  output logic [CMD_W-1:0] word
);
  localparam int BC_W = $clog2(CMD_W);

  logic [BC_W-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (!sen) begin
        bit_cnt <= '0;
      end else begin
        word <= {word[CMD_W-2:0], sdi};
        if (bit_cnt == BC_W'(CMD_W-1)) begin
          bit_cnt  <= '0;
          word_vld <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_col_decode.sv
module cmd_col_decode
  import cmd_periph_pkg::*;
#(
  parameter int NCOL = 64
) (
  input  logic [ARG_W-1:0] start,
  input  logic [SZ_W-1:0]  size,
  output logic [NCOL-1:0]  mask
);
  localparam int SPAN_W = ARG_W + 1;

  logic [SPAN_W-1:0] lo;
  logic [SPAN_W-1:0] hi_ex;
  logic              all_cols;

  assign lo       = {1'b0, start};
  assign hi_ex    = lo + (SPAN_W'(1) << size);
  assign all_cols = (size == SZ_ALL);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam logic [SPAN_W-1:0] CI = SPAN_W'(c);
    assign mask[c] = all_cols | ((CI >= lo) & (CI < hi_ex));
  end
endmodule

// File: rtl/cmd_clk_sel.sv
module cmd_clk_sel (
  input  logic clk,
  input  logic rst,
  input  logic want_ro,
  input  logic want_acq,
  output logic ro_en,
  output logic acq_en
);
  logic [1:0] want;
  logic [1:0] cur;

  assign want = want_ro ? 2'b10 : (want_acq ? 2'b01 : 2'b00);

  always_ff @(posedge clk) begin
    if (rst)                            cur <= 2'b00;
    else if (cur != want && cur != '0)  cur <= 2'b00;
    else                                cur <= want;
  end

  assign ro_en  = cur[1];
  assign acq_en = cur[0];
endmodule

// File: rtl/cmd_periph_ctrl.sv
module cmd_periph_ctrl
  import cmd_periph_pkg::*;
#(
  parameter int NCOL       = 64,
  parameter int RO_CYCLES  = 32,
  parameter int CFG_CYCLES = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_sen,
  input  logic             cmd_sdi,
  input  logic             shutter_pin,
  input  logic             pwroff_pin,
  input  logic             tpulse_pin,
  output logic [NCOL-1:0]  col_read,
  output logic [NCOL-1:0]  col_load,
  output logic             gcfg_we,
  output logic [8:0]       gcfg_addr,
  output logic [13:0]      gcfg_data,
  output logic             arr_rst,
  output logic             cfg_done,
  output logic             acq_clk_en,
  output logic             ro_clk_en,
  output logic             shutter_out,
  output logic             pwroff_out,
  output logic             tpulse_out
);
  localparam int MAXLEN = (RO_CYCLES > CFG_CYCLES) ? RO_CYCLES : CFG_CYCLES;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  logic             rx_vld;
  logic [CMD_W-1:0] rx_word;
  cmd_t             cw;
  logic [NCOL-1:0]  dec_mask;

  seq_e             state;
  logic [NCOL-1:0]  mask_r;
  logic             is_cfg;
  logic             full_r;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             ro_req;

  cmd_shift_rx u_rx (
    .clk      (clk),
    .rst      (rst),
    .sen      (cmd_sen),
    .sdi      (cmd_sdi),
    .word_vld (rx_vld),
    .word     (rx_word)
  );

  assign cw = cmd_t'(rx_word);

  cmd_col_decode #(.NCOL(NCOL)) u_dec (
    .start (cw.arg),
    .size  (cw.sz),
    .mask  (dec_mask)
  );

  assign ro_req = (state == S_CLKW) || (state == S_RUN);

  cmd_clk_sel u_clk (
    .clk      (clk),
    .rst      (rst),
    .want_ro  (ro_req),
    .want_acq (shutter_out),
    .ro_en    (ro_clk_en),
    .acq_en   (acq_clk_en)
  );

  assign last_cnt = is_cfg ? CNT_W'(CFG_CYCLES - 1) : CNT_W'(RO_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mask_r    <= '0;
      is_cfg    <= 1'b0;
      full_r    <= 1'b0;
      cnt       <= '0;
      col_read  <= '0;
      col_load  <= '0;
      gcfg_we   <= 1'b0;
      gcfg_addr <= '0;
      gcfg_data <= '0;
      arr_rst   <= 1'b0;
      cfg_done  <= 1'b0;
    end else begin
      gcfg_we <= 1'b0;
      arr_rst <= 1'b0;
      case (state)
        S_IDLE: begin
          if (rx_vld) begin
            if (cw.op == OP_READ || cw.op == OP_PCFG) begin
              mask_r <= dec_mask;
              is_cfg <= (cw.op == OP_PCFG);
              full_r <= (cw.sz == SZ_ALL);
              state  <= S_CLKW;
            end else if (cw.op == OP_GWR) begin
              gcfg_addr <= cw.arg;
              state     <= S_WDATA;
            end else if (cw.op == OP_ARST) begin
              arr_rst  <= 1'b1;
              cfg_done <= 1'b0;
            end
          end
        end
        S_WDATA: begin
          if (rx_vld) begin
            gcfg_we   <= 1'b1;
            gcfg_data <= rx_word;
            state     <= S_IDLE;
          end
        end
        S_CLKW: begin
          if (ro_clk_en) begin
            state <= S_RUN;
            cnt   <= '0;
            if (is_cfg) col_load <= mask_r;
            else        col_read <= mask_r;
          end
        end
        S_RUN: begin
          if (cnt == last_cnt) begin
            state    <= S_IDLE;
            col_read <= '0;
            col_load <= '0;
            if (is_cfg && full_r) cfg_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shutter_out <= 1'b0;
      pwroff_out  <= 1'b0;
      tpulse_out  <= 1'b0;
    end else begin
      shutter_out <= shutter_pin;
      pwroff_out  <= pwroff_pin;
      tpulse_out  <= tpulse_pin & cfg_done;
    end
  end
endmodule

// File: rtl/cmd_periph_chk.sv
module cmd_periph_chk #(
  parameter int NCOL = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            shutter_pin,
  input logic            pwroff_pin,
  input logic [NCOL-1:0] col_read,
  input logic [NCOL-1:0] col_load,
  input logic            gcfg_we,
  input logic            arr_rst,
  input logic            cfg_done,
  input logic            acq_clk_en,
  input logic            ro_clk_en,
  input logic            shutter_out,
  input logic            pwroff_out,
  input logic            tpulse_out
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_CLK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(acq_clk_en && ro_clk_en)); // R10
  AST_ACQ_BREAK: assert property (@(posedge clk) disable iff (rst)
    acq_clk_en |=> !ro_clk_en); // R10
  AST_RO_BREAK: assert property (@(posedge clk) disable iff (rst)
    ro_clk_en |=> !acq_clk_en); // R10
  AST_STROBE_CLK: assert property (@(posedge clk) disable iff (rst)
    ((|col_read) || (|col_load)) |-> ro_clk_en); // R11
  AST_RD_LD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !((|col_read) && (|col_load))); // R4
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    gcfg_we |=> !gcfg_we); // R6
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    arr_rst |=> !arr_rst); // R7
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    arr_rst |-> !cfg_done); // R7
  AST_TP_GATED: assert property (@(posedge clk) disable iff (rst)
    tpulse_out |-> $past(cfg_done)); // R12
  AST_SHUT_PASS: assert property (@(posedge clk) disable iff (rst)
    seen |-> (shutter_out == $past(shutter_pin))); // R12
  AST_PWR_PASS: assert property (@(posedge clk) disable iff (rst)
    seen |-> (pwroff_out == $past(pwroff_pin))); // R12
endmodule

bind cmd_periph_ctrl cmd_periph_chk #(.NCOL(NCOL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .shutter_pin (shutter_pin),
  .pwroff_pin  (pwroff_pin),
  .col_read    (col_read),
  .col_load    (col_load),
  .gcfg_we     (gcfg_we),
  .arr_rst     (arr_rst),
  .cfg_done    (cfg_done),
  .acq_clk_en  (acq_clk_en),
  .ro_clk_en   (ro_clk_en),
  .shutter_out (shutter_out),
  .pwroff_out  (pwroff_out),
  .tpulse_out  (tpulse_out)
);

// File: tb/cmd_periph_ctrl_tb.sv
module cmd_periph_ctrl_tb;
  localparam int NCOL = 64;
  localparam int ROC  = 32;
  localparam int CFC  = 24;
  localparam int NV   = 6;

  localparam logic [13:0] V_CMD [NV] = '{
    14'b001_00_000000101, 14'b001_01_000001010, 14'b001_10_000111110,
    14'b001_11_000000000, 14'b010_10_000000000, 14'b010_11_000000000};
  localparam logic [63:0] V_RD [NV] = '{
    64'h20, 64'hC00, 64'hC000_0000_0000_0000, {64{1'b1}}, 64'h0, 64'h0};
  localparam logic [63:0] V_LD [NV] = '{
    64'h0, 64'h0, 64'h0, 64'h0, 64'hF, {64{1'b1}}};
  localparam int V_LEN [NV] = '{ROC, ROC, ROC, ROC, CFC, CFC};

  logic clk = 0, rst = 1;
  logic cmd_sen = 0, cmd_sdi = 0, shutter_pin = 0, pwroff_pin = 0, tpulse_pin = 0;
  logic [NCOL-1:0] col_read, col_load;
  logic gcfg_we, arr_rst, cfg_done, acq_clk_en, ro_clk_en;
  logic shutter_out, pwroff_out, tpulse_out;
  logic [8:0] gcfg_addr;
  logic [13:0] gcfg_data;

  int errors = 0, checks = 0;
  int we_cnt = 0, rst_cnt = 0, bad_both = 0, bad_sw = 0, bad_strb = 0;
  logic [8:0] we_addr;
  logic [13:0] we_data;
  logic prev_acq = 0, prev_ro = 0;
  logic [63:0] m_rd, m_ld;
  int m_len;

  always #10 clk = ~clk;

  cmd_periph_ctrl #(.NCOL(NCOL), .RO_CYCLES(ROC), .CFG_CYCLES(CFC)) u_dut (
    .clk(clk), .rst(rst), .cmd_sen(cmd_sen), .cmd_sdi(cmd_sdi),
    .shutter_pin(shutter_pin), .pwroff_pin(pwroff_pin), .tpulse_pin(tpulse_pin),
    .col_read(col_read), .col_load(col_load), .gcfg_we(gcfg_we),
    .gcfg_addr(gcfg_addr), .gcfg_data(gcfg_data), .arr_rst(arr_rst),
    .cfg_done(cfg_done), .acq_clk_en(acq_clk_en), .ro_clk_en(ro_clk_en),
    .shutter_out(shutter_out), .pwroff_out(pwroff_out), .tpulse_out(tpulse_out));

  always @(negedge clk) if (!rst) begin
    if (gcfg_we) begin we_cnt++; we_addr = gcfg_addr; we_data = gcfg_data; end
    if (arr_rst) rst_cnt++;
    if (acq_clk_en && ro_clk_en) bad_both++;
    if ((prev_acq && ro_clk_en) || (prev_ro && acq_clk_en)) bad_sw++;
    if (((|col_read) || (|col_load)) && !ro_clk_en) bad_strb++;
    prev_acq = acq_clk_en;
    prev_ro  = ro_clk_en;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk); cmd_sen = 1; cmd_sdi = w[i];
    end
    @(negedge clk); cmd_sen = 0; cmd_sdi = 0;
  endtask

  task automatic measure(input int wait_max);
    m_rd = 0; m_ld = 0; m_len = 0;
    for (int t = 0; t < wait_max; t++) begin
      @(negedge clk);
      if ((|col_read) || (|col_load)) begin
        m_rd = col_read; m_ld = col_load;
        while ((|col_read) || (|col_load)) begin m_len++; @(negedge clk); end
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0, r0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk("R4 reset col_read", col_read, 0);
    chk("R5 reset col_load", col_load, 0);
    chk("R8 reset cfg_done", cfg_done, 0);
    chk("R10 reset clocks", {acq_clk_en, ro_clk_en}, 0);

    // R12: test pulse blocked before configuration
    tpulse_pin = 1; idle(3);
    chk("R12 tpulse blocked", tpulse_out, 0);

    // R2 R3 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      send(V_CMD[i]);
      measure(40);
      chk("R3 read mask", m_rd, V_RD[i]);
      chk("R3 load mask", m_ld, V_LD[i]);
      chk(V_CMD[i][11] ? "R4 read length" : "R5 load length", m_len, V_LEN[i]);
      if (i == 4) chk("R8 partial load keeps cfg_done low", cfg_done, 0);
      idle(3);
    end
    chk("R8 cfg_done after full load", cfg_done, 1);
    chk("R12 tpulse passes when configured", tpulse_out, 1);
    chk("R10 idle no clock", {acq_clk_en, ro_clk_en}, 0);

    // R6 global write
    w0 = we_cnt;
    send(14'b011_00_110100101);
    send(14'h1ABC);
    idle(3);
    chk("R6 one write pulse", we_cnt - w0, 1);
    chk("R6 write addr", we_addr, 9'h1A5);
    chk("R6 write data", we_data, 14'h1ABC);

    // R7 array reset
    r0 = rst_cnt;
    send(14'b100_00_000000000);
    idle(3);
    chk("R7 one reset pulse", rst_cnt - r0, 1);
    chk("R7 cfg_done cleared", cfg_done, 0);
    chk("R12 tpulse blocked after reset", tpulse_out, 0);
    tpulse_pin = 0;

    // R1 aborted shift then full word
    for (int i = 0; i < 7; i++) begin @(negedge clk); cmd_sen = 1; cmd_sdi = 1; end
    @(negedge clk); cmd_sen = 0;
    send(14'b001_00_000000011);
    measure(40);
    chk("R1 word after abort mask", m_rd, 64'h8);
    chk("R1 word after abort length", m_len, ROC);
    idle(3);

    // R2 unknown opcode ignored
    w0 = we_cnt; r0 = rst_cnt;
    send(14'b111_11_000000000);
    measure(60);
    chk("R2 unknown op no strobe", m_len, 0);
    chk("R2 unknown op no write/reset", (we_cnt - w0) + (rst_cnt - r0), 0);
    chk("R2 unknown op clocks off", {acq_clk_en, ro_clk_en}, 0);

    // R9 command during operation ignored
    fork
      begin send(14'b001_00_000000101); send(14'b001_00_000000111); end
      measure(40);
    join
    chk("R9 first command mask", m_rd, 64'h20);
    measure(80);
    chk("R9 second command dropped", m_len, 0);

    // R10 R12 shutter and clock switching
    shutter_pin = 1; idle(1);
    chk("R12 shutter follows", shutter_out, 1);
    idle(3);
    chk("R10 counting clock when shutter open", {acq_clk_en, ro_clk_en}, 2'b10);
    fork
      send(14'b001_00_000000000);
      measure(40);
    join
    chk("R10 readout with shutter open", m_len, ROC);
    idle(4);
    chk("R10 counting clock restored", {acq_clk_en, ro_clk_en}, 2'b10);
    pwroff_pin = 1; idle(1);
    chk("R12 pwroff follows", pwroff_out, 1);
    shutter_pin = 0; pwroff_pin = 0; idle(4);
    chk("R10 clocks off when idle and shutter closed", {acq_clk_en, ro_clk_en}, 0);

    chk("R10 never both clocks", bad_both, 0);
    chk("R10 no direct clock switch", bad_sw, 0);
    chk("R11 strobes only with readout clock", bad_strb, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule